// File: doc/BRIEF.md
# Five-Channel Memory Transfer Engine

This block moves data on its own, one element at a time, over a simple single-master memory bus. Five channels each hold a programmed source address, destination address, element count, transfer direction and separate read and write element sizes. A channel that moves data to or from a peripheral advances one element for each hardware request from its own request line, or runs freely while its software trigger bit is set. A memory-to-memory channel runs back to back as soon as it is enabled. Each element is one bus read followed by one bus write. The read and write widths are set independently. Narrow read data is zero-extended and wide read data is cut down to the low bits of the write width.

One shared engine serves all channels. The lowest-numbered channel that is ready always wins, and the choice is made again before every element, so a higher-priority channel can step in between two elements of a lower one. Every channel raises a half-transfer flag, a completion flag and a bus-error flag, and these drive a per-channel interrupt line. In circular mode a channel that reaches a count of zero reloads its count and both start addresses and keeps going with no software action.

Top module: `mcdma_top`

## Requirements
- R1: Registers use word addresses. Channel c has CTRL at 4c, SRC at 4c+1, DST at 4c+2 and COUNT at 4c+3; FLAGS is at 20. CTRL bits: 0 enable, 1 software trigger, 3:2 direction (0 peripheral-to-memory, 1 memory-to-peripheral, 2 memory-to-memory), 4 circular, 5 source increment, 6 destination increment, 8:7 source size, 10:9 destination size, 11 completion interrupt enable, 12 half interrupt enable. Size code 0 is 8 bits, 1 is 16 bits and 2 is 32 bits. Writing SRC, DST or COUNT sets both the reload value and the live value; reading them returns the live value.
- R2: When several channels are ready, the lowest-numbered one is served. The choice is made again after every single element.
- R3: A peripheral channel moves an element only while its request input is high or its software trigger bit is set. Each completed element pulses that channel's acknowledge output for one cycle. A memory-to-memory channel needs no request.
- R4: Each element is a read at the source address with the source size, followed by a write at the destination address with the destination size. The bus request, address and direction stay steady until acknowledged.
- R5: Write data is the read data masked to the source width, then masked to the destination width.
- R6: With increment enabled, an address steps by its own side's element size in bytes (1, 2 or 4) after each element. With increment disabled, the address stays fixed.
- R7: The count drops by one per element. At zero the completion flag (FLAGS bit 3c) is set, and a non-circular channel stops.
- R8: The half flag (FLAGS bit 3c+1) is set when the remaining count after an element equals the programmed count divided by two, rounded down.
- R9: In circular mode, reaching zero reloads the count and both addresses from their programmed values, and transfers continue.
- R10: irq[c] is high while the completion flag and its enable are both set, or the half flag and its enable are both set, or the error flag is set. Writing ones to FLAGS clears the matching flags.
- R11: A bus error on either access sets the error flag (FLAGS bit 3c+2) and clears the channel's enable bit. An element that hits an error is not counted.
- R12: After reset all registers and flags read zero, and no bus request, acknowledge or interrupt is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | RAW (5) | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| dreq | input | NCH (5) | Per-channel hardware request |
| dack | output | NCH (5) | Per-channel element-done pulse |
| irq | output | NCH (5) | Per-channel interrupt |
| mem_req | output | 1 | Bus access request |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | AW (32) | Byte address |
| mem_size | output | 2 | Access size code |
| mem_wdata | output | 32 | Right-aligned write data |
| mem_rdata | input | 32 | Right-aligned read data, valid with mem_ack |
| mem_ack | input | 1 | Access complete |
| mem_err | input | 1 | Access failed, valid with mem_ack |

## Verification
The embedded properties check, on every cycle, the following: the grant goes to at most one channel, and to the lowest one ready; bus requests hold steady until acknowledged; at most one acknowledge pulse is active; 8-bit writes carry no upper data; the live count never exceeds the programmed count; an error drops the enable bit; and a circular wrap reloads the count. The ordering of elements when a higher channel joins partway through, the exact data and addresses after size conversion and increment, the timing of the half flag, address reload after a wrap, and interrupt masking and clearing are shown only by the bench scenarios. There, a behavioural model predicts every write and compares it on the clock where the write completes.

// File: rtl/mcdma_pkg.sv
`timescale 1ns/1ps
package mcdma_pkg;

  localparam int DW     = 32;
  localparam int CTRL_W = 13;

  typedef enum logic [1:0] {
    XFER_P2M = 2'd0,
    XFER_M2P = 2'd1,
    XFER_M2M = 2'd2,
    XFER_RSV = 2'd3
  } dir_e;

  typedef struct packed {
    logic       htie;
    logic       tcie;
    logic [1:0] dsz;
    logic [1:0] ssz;
    logic       dinc;
    logic       sinc;
    logic       circ;
    logic [1:0] dir;
    logic       swtrig;
    logic       en;
  } ctrl_t;

  function automatic logic [DW-1:0] size_mask(input logic [1:0] sz);
    case (sz)
      2'd0:    size_mask = 32'h0000_00FF;
      2'd1:    size_mask = 32'h0000_FFFF;
      default: size_mask = 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic logic [2:0] size_step(input logic [1:0] sz);
    case (sz)
      2'd0:    size_step = 3'd1;
      2'd1:    size_step = 3'd2;
      default: size_step = 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/mcdma_arb.sv
`timescale 1ns/1ps
module mcdma_arb #(
  parameter int NCH = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] want,
  output logic [NCH-1:0] gnt,
  output logic           any
);

  logic [NCH:0] seen;
  assign seen[0] = 1'b0;

  for (genvar i = 0; i < NCH; i++) begin : g_pri
    assign gnt[i]    = want[i] & ~seen[i];
    assign seen[i+1] = seen[i] | want[i];
  end

  assign any = seen[NCH];

  // R2
  gnt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));

  // R2
  gnt_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt != '0) |-> (((gnt - 1'b1) & want) == '0));

endmodule

// File: rtl/mcdma_chan.sv
`timescale 1ns/1ps
module mcdma_chan
  import mcdma_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctrl,
  input  logic              wr_src,
  input  logic              wr_dst,
  input  logic              wr_cnt,
  input  logic [CTRL_W-1:0] ctrl_wd,
  input  logic [AW-1:0]     addr_wd,
  input  logic [CW-1:0]     cnt_wd,
  input  logic [2:0]        flag_clr,
  input  logic              hw_req,
  input  logic              elem_done,
  input  logic              elem_err,
  output ctrl_t             ctrl,
  output logic [AW-1:0]     src_addr,
  output logic [AW-1:0]     dst_addr,
  output logic [CW-1:0]     cnt,
  output logic [2:0]        flags,
  output logic              want,
  output logic              irq
);

  ctrl_t         ctrl_q, ctrl_d;
  logic [AW-1:0] sbase_q, sbase_d, dbase_q, dbase_d;
  logic [AW-1:0] scur_q, scur_d, dcur_q, dcur_d;
  logic [CW-1:0] init_q, init_d, cnt_q, cnt_d, left;
  logic [2:0]    flg_q, flg_d, flg_set;
  logic          step_ok;
  logic          cfg_ld, base_ld, run_ld, flg_ld;

  assign step_ok = elem_done && (cnt_q != '0);
  assign left    = cnt_q - 1'b1;

  assign cfg_ld  = wr_ctrl | elem_err;
  assign base_ld = wr_src | wr_dst | wr_cnt;
  assign run_ld  = step_ok | wr_src | wr_dst | wr_cnt;
  assign flg_ld  = step_ok | elem_err | (|flag_clr);

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_ctrl)  ctrl_d = ctrl_t'(ctrl_wd);
    if (elem_err) ctrl_d.en = 1'b0;

    sbase_d = wr_src ? addr_wd : sbase_q;
    dbase_d = wr_dst ? addr_wd : dbase_q;
    init_d  = wr_cnt ? cnt_wd  : init_q;

    scur_d  = scur_q;
    dcur_d  = dcur_q;
    cnt_d   = cnt_q;
    flg_set = 3'b000;

    if (step_ok) begin
      if (ctrl_q.sinc) scur_d = scur_q + AW'(size_step(ctrl_q.ssz));
      if (ctrl_q.dinc) dcur_d = dcur_q + AW'(size_step(ctrl_q.dsz));
      cnt_d = left;
      if (left == (init_q >> 1)) flg_set[1] = 1'b1;
      if (left == '0) begin
        flg_set[0] = 1'b1;
        if (ctrl_q.circ) begin
          cnt_d  = init_q;
          scur_d = sbase_q;
          dcur_d = dbase_q;
        end
      end
    end
    if (elem_err) flg_set[2] = 1'b1;

    if (wr_src) scur_d = addr_wd;
    if (wr_dst) dcur_d = addr_wd;
    if (wr_cnt) cnt_d  = cnt_wd;

    flg_d = (flg_q & ~flag_clr) | flg_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      sbase_q <= '0;
      dbase_q <= '0;
      init_q  <= '0;
      scur_q  <= '0;
      dcur_q  <= '0;
      cnt_q   <= '0;
      flg_q   <= '0;
    end else begin
      if (cfg_ld)  ctrl_q <= ctrl_d;
      if (base_ld) begin
        sbase_q <= sbase_d;
        dbase_q <= dbase_d;
        init_q  <= init_d;
      end
      if (run_ld) begin
        scur_q <= scur_d;
        dcur_q <= dcur_d;
        cnt_q  <= cnt_d;
      end
      if (flg_ld)  flg_q <= flg_d;
    end
  end

  assign ctrl     = ctrl_q;
  assign src_addr = scur_q;
  assign dst_addr = dcur_q;
  assign cnt      = cnt_q;
  assign flags    = flg_q;

  assign want = ctrl_q.en && (cnt_q != '0) &&
                ((ctrl_q.dir == XFER_M2M) || (ctrl_q.dir == XFER_RSV) ||
                 hw_req || ctrl_q.swtrig);

  assign irq = (flg_q[0] & ctrl_q.tcie) | (flg_q[1] & ctrl_q.htie) | flg_q[2];

  // R7
  cnt_within_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= init_q);

  // R11
  err_drops_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    elem_err |=> !ctrl_q.en);

  // R9
  circ_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (elem_done && cnt_q == CW'(1) && ctrl_q.circ && !wr_cnt) |=> (cnt_q == init_q));

endmodule

// File: rtl/mcdma_eng.sv
`timescale 1ns/1ps
module mcdma_eng
  import mcdma_pkg::*;
#(
  parameter int NCH = 5,
  parameter int AW  = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NCH-1:0]          gnt,
  input  logic                    any_req,
  input  logic [NCH-1:0][AW-1:0]  src_addr,
  input  logic [NCH-1:0][AW-1:0]  dst_addr,
  input  logic [NCH-1:0][1:0]     ssz,
  input  logic [NCH-1:0][1:0]     dsz,
  output logic                    mem_req,
  output logic                    mem_we,
  output logic [AW-1:0]           mem_addr,
  output logic [1:0]              mem_size,
  output logic [DW-1:0]           mem_wdata,
  input  logic [DW-1:0]           mem_rdata,
  input  logic                    mem_ack,
  input  logic                    mem_err,
  output logic [NCH-1:0]          elem_done,
  output logic [NCH-1:0]          elem_err
);

  typedef enum logic [1:0] {E_IDLE = 2'd0, E_RD = 2'd1, E_WR = 2'd2} est_e;

  est_e           st_q, st_d;
  logic [NCH-1:0] sel_q, sel_d;
  logic [DW-1:0]  hold_q, hold_d;
  logic [AW-1:0]  cur_src, cur_dst;
  logic [1:0]     cur_ssz, cur_dsz;
  logic           st_ld, sel_ld, hold_ld;

  always_comb begin
    cur_src = '0;
    cur_dst = '0;
    cur_ssz = '0;
    cur_dsz = '0;
    for (int i = 0; i < NCH; i++) begin
      if (sel_q[i]) begin
        cur_src = src_addr[i];
        cur_dst = dst_addr[i];
        cur_ssz = ssz[i];
        cur_dsz = dsz[i];
      end
    end
  end

  always_comb begin
    st_d      = st_q;
    sel_d     = sel_q;
    hold_d    = hold_q;
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_size  = 2'd0;
    mem_wdata = '0;
    elem_done = '0;
    elem_err  = '0;
    case (st_q)
      E_IDLE: begin
        if (any_req) begin
          sel_d = gnt;
          st_d  = E_RD;
        end
      end
      E_RD: begin
        mem_req  = 1'b1;
        mem_addr = cur_src;
        mem_size = cur_ssz;
        if (mem_ack) begin
          if (mem_err) begin
            elem_err = sel_q;
            st_d     = E_IDLE;
          end else begin
            hold_d = mem_rdata & size_mask(cur_ssz);
            st_d   = E_WR;
          end
        end
      end
      E_WR: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = cur_dst;
        mem_size  = cur_dsz;
        mem_wdata = hold_q & size_mask(cur_dsz);
        if (mem_ack) begin
          if (mem_err) elem_err  = sel_q;
          else         elem_done = sel_q;
          st_d = E_IDLE;
        end
      end
      default: st_d = E_IDLE;
    endcase
  end

  assign st_ld   = (st_d != st_q);
  assign sel_ld  = (st_q == E_IDLE);
  assign hold_ld = (st_q == E_RD) && mem_ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= E_IDLE;
      sel_q  <= '0;
      hold_q <= '0;
    end else begin
      if (st_ld)   st_q   <= st_d;
      if (sel_ld)  sel_q  <= sel_d;
      if (hold_ld) hold_q <= hold_d;
    end
  end

  // R4
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  // R4
  done_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (elem_done != '0) |-> (mem_we && mem_ack));

endmodule

// File: rtl/mcdma_top.sv
`timescale 1ns/1ps
module mcdma_top
  import mcdma_pkg::*;
#(
  parameter int NCH = 5,
  parameter int AW  = 32,
  parameter int CW  = 16,
  parameter int RAW = $clog2(NCH * 4 + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_we,
  input  logic [RAW-1:0]  reg_addr,
  input  logic [31:0]     reg_wdata,
  output logic [31:0]     reg_rdata,
  input  logic [NCH-1:0]  dreq,
  output logic [NCH-1:0]  dack,
  output logic [NCH-1:0]  irq,
  output logic            mem_req,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [1:0]      mem_size,
  output logic [31:0]     mem_wdata,
  input  logic [31:0]     mem_rdata,
  input  logic            mem_ack,
  input  logic            mem_err
);

  localparam logic [RAW-1:0] FLAG_IDX = RAW'(NCH * 4);
  localparam int             FW       = 3 * NCH;

  logic [1:0] rst_sync_q;
  logic       srst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign srst_n = rst_sync_q[1];

  ctrl_t                   ctrl_v [NCH];
  logic [NCH-1:0][AW-1:0]  src_v, dst_v;
  logic [NCH-1:0][1:0]     ssz_v, dsz_v;
  logic [CW-1:0]           cnt_v [NCH];
  logic [FW-1:0]           flags_all;
  logic [NCH-1:0]          want, gnt, done_v, err_v;
  logic [NCH-1:0]          wr_ctrl, wr_src, wr_dst, wr_cnt;
  logic                    any_req;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    localparam logic [RAW-1:0] A_CTRL = RAW'(4 * i);
    localparam logic [RAW-1:0] A_SRC  = RAW'(4 * i + 1);
    localparam logic [RAW-1:0] A_DST  = RAW'(4 * i + 2);
    localparam logic [RAW-1:0] A_CNT  = RAW'(4 * i + 3);

    logic [2:0] clr;
    logic [2:0] flg;

    assign wr_ctrl[i] = reg_we && (reg_addr == A_CTRL);
    assign wr_src[i]  = reg_we && (reg_addr == A_SRC);
    assign wr_dst[i]  = reg_we && (reg_addr == A_DST);
    assign wr_cnt[i]  = reg_we && (reg_addr == A_CNT);
    assign clr        = (reg_we && (reg_addr == FLAG_IDX)) ? reg_wdata[3*i +: 3] : 3'b000;

    mcdma_chan #(.AW(AW), .CW(CW)) u_chan (
      .clk       (clk),
      .rst_n     (srst_n),
      .wr_ctrl   (wr_ctrl[i]),
      .wr_src    (wr_src[i]),
      .wr_dst    (wr_dst[i]),
      .wr_cnt    (wr_cnt[i]),
      .ctrl_wd   (reg_wdata[CTRL_W-1:0]),
      .addr_wd   (reg_wdata[AW-1:0]),
      .cnt_wd    (reg_wdata[CW-1:0]),
      .flag_clr  (clr),
      .hw_req    (dreq[i]),
      .elem_done (done_v[i]),
      .elem_err  (err_v[i]),
      .ctrl      (ctrl_v[i]),
      .src_addr  (src_v[i]),
      .dst_addr  (dst_v[i]),
      .cnt       (cnt_v[i]),
      .flags     (flg),
      .want      (want[i]),
      .irq       (irq[i])
    );

    assign ssz_v[i]          = ctrl_v[i].ssz;
    assign dsz_v[i]          = ctrl_v[i].dsz;
    assign flags_all[3*i +: 3] = flg;
  end

  mcdma_arb #(.NCH(NCH)) u_arb (
    .clk   (clk),
    .rst_n (srst_n),
    .want  (want),
    .gnt   (gnt),
    .any   (any_req)
  );

  mcdma_eng #(.NCH(NCH), .AW(AW)) u_eng (
    .clk       (clk),
    .rst_n     (srst_n),
    .gnt       (gnt),
    .any_req   (any_req),
    .src_addr  (src_v),
    .dst_addr  (dst_v),
    .ssz       (ssz_v),
    .dsz       (dsz_v),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_size  (mem_size),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .mem_ack   (mem_ack),
    .mem_err   (mem_err),
    .elem_done (done_v),
    .elem_err  (err_v)
  );

  assign dack = done_v;

  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < NCH; i++) begin
      if (reg_addr == RAW'(4 * i))     reg_rdata = 32'(ctrl_v[i]);
      if (reg_addr == RAW'(4 * i + 1)) reg_rdata = 32'(src_v[i]);
      if (reg_addr == RAW'(4 * i + 2)) reg_rdata = 32'(dst_v[i]);
      if (reg_addr == RAW'(4 * i + 3)) reg_rdata = 32'(cnt_v[i]);
    end
    if (reg_addr == FLAG_IDX) reg_rdata = 32'(flags_all);
  end

  // R3
  dack_onehot_chk: assert property (@(posedge clk) disable iff (!srst_n)
    $onehot0(dack));

  // R5
  narrow_wdata_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (mem_req && mem_we && mem_size == 2'd0) |-> (mem_wdata[31:8] == '0));

endmodule

// File: tb/mcdma_top_bench.sv
`timescale 1ns/1ps
module mcdma_top_bench;

  localparam int NCH   = 5;
  localparam int FLAGS = 20;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we;
  logic [4:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic [4:0]  dreq, dack, irq;
  logic        mem_req, mem_we, mem_ack, mem_err;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [1:0]  mem_size;

  always #2.5 clk = ~clk;

  mcdma_top u_mcdma_top (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dreq(dreq), .dack(dack),
    .irq(irq), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_size(mem_size), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_ack(mem_ack), .mem_err(mem_err)
  );

  int n_chk  = 0;
  int n_fail = 0;
  bit ended  = 0;

  logic [31:0] qa[$];
  logic [31:0] qd[$];
  logic [1:0]  qs[$];

  function automatic logic [31:0] pat(input logic [31:0] a);
    return {a[7:0] ^ 8'hC3, a[7:0] + 8'h11, ~a[7:0], a[7:0]};
  endfunction

  function automatic logic [31:0] cw(bit en, bit sw, logic [1:0] dir, bit circ,
                                     bit sinc, bit dinc, logic [1:0] ssz,
                                     logic [1:0] dsz, bit tcie, bit htie);
    return {19'b0, htie, tcie, dsz, ssz, dinc, sinc, circ, dir, sw, en};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic report();
    if (!ended) begin
      ended = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // memory model: ack on every other cycle of a request, error in 0xE region
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_ack   <= 1'b0;
      mem_err   <= 1'b0;
      mem_rdata <= '0;
    end else begin
      mem_ack   <= mem_req && !mem_ack;
      mem_err   <= mem_req && !mem_ack && (mem_addr[31:28] == 4'hE);
      mem_rdata <= pat(mem_addr);
    end
  end

  // reference comparison of every completed write
  always @(negedge clk) begin
    if (rst_n && mem_req && mem_we && mem_ack) begin
      if (qa.size() == 0) begin
        n_chk++;
        n_fail++;
        $display("FAIL R7 unexpected write actual=%h expected=none", mem_addr);
      end else begin
        check("R6 write address", mem_addr, qa.pop_front());
        check("R5 write data", mem_wdata, qd.pop_front());
        check("R4 write size", {30'b0, mem_size}, {30'b0, qs.pop_front()});
      end
    end
  end

  task automatic exp_wr(input logic [31:0] a, input logic [31:0] d, input logic [1:0] s);
    qa.push_back(a);
    qd.push_back(d);
    qs.push_back(s);
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    reg_we    = 1'b1;
    reg_addr  = 5'(a);
    reg_wdata = d;
    @(negedge clk);
    reg_we    = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input int a, input logic [31:0] exp);
    @(negedge clk);
    reg_addr = 5'(a);
    #0.5;
    check(tag, reg_rdata, exp);
  endtask

  task automatic drain(input string tag);
    int t = 0;
    while (qa.size() != 0 && t < 3000) begin
      @(negedge clk);
      t++;
    end
    repeat (10) @(negedge clk);
    check(tag, qa.size(), 0);
  endtask

  task automatic pulse_req(input int ch, input int n);
    int k = 0;
    int t = 0;
    dreq[ch] = 1'b1;
    while (k < n && t < 3000) begin
      @(negedge clk);
      t++;
      if (dack[ch]) k++;
      if (k == n) dreq[ch] = 1'b0;
    end
    dreq[ch] = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic setup(input int ch, input logic [31:0] s, input logic [31:0] d, input int n);
    wr(ch * 4 + 1, s);
    wr(ch * 4 + 2, d);
    wr(ch * 4 + 3, 32'(n));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    report();
  end

  initial begin
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0; dreq = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R12 reset state
    check("R12 mem_req after reset", {31'b0, mem_req}, 0);
    check("R12 dack after reset", {27'b0, dack}, 0);
    check("R12 irq after reset", {27'b0, irq}, 0);
    rd_chk("R12 ctrl0 after reset", 0, 0);
    rd_chk("R12 flags after reset", FLAGS, 0);

    // S1: memory-to-memory, 32->32, both increment (R1 R4 R6 R7 R8 R10)
    for (int i = 0; i < 4; i++) exp_wr(32'h200 + 4*i, pat(32'h100 + 4*i), 2'd2);
    setup(0, 32'h100, 32'h200, 4);
    wr(0, cw(1, 0, 2'd2, 0, 1, 1, 2'd2, 2'd2, 1, 0));
    drain("R7 s1 all writes seen");
    rd_chk("R7 R8 s1 flags", FLAGS, 32'h3);
    rd_chk("R7 s1 count at zero", 3, 0);
    rd_chk("R1 s1 dst live address", 2, 32'h210);
    check("R10 s1 irq completion", {27'b0, irq}, 32'h1);
    wr(FLAGS, 32'h1);
    rd_chk("R10 s1 w1c completion only", FLAGS, 32'h2);
    check("R10 s1 irq masked half", {27'b0, irq}, 0);
    wr(FLAGS, 32'h2);

    // S2: priority and size conversion (R2 R5 R6)
    for (int i = 0; i < 3; i++) exp_wr(32'h300, pat(32'h400 + i) & 32'hFF, 2'd2);
    for (int i = 0; i < 2; i++) exp_wr(32'h500 + 2*i, pat(32'h140 + 4*i) & 32'hFFFF, 2'd1);
    setup(2, 32'h400, 32'h300, 3);
    setup(4, 32'h140, 32'h500, 2);
    wr(8,  cw(1, 0, 2'd2, 0, 1, 0, 2'd0, 2'd2, 0, 0));
    wr(16, cw(1, 0, 2'd2, 0, 1, 1, 2'd2, 2'd1, 0, 0));
    drain("R2 s2 all writes in priority order");
    rd_chk("R8 s2 flags", FLAGS, (32'h3 << 6) | (32'h3 << 12));
    check("R10 s2 irq stays low without enables", {27'b0, irq}, 0);
    wr(FLAGS, 32'h7FFF);
    rd_chk("R10 s2 flags cleared", FLAGS, 0);

    // S3: peripheral requests and re-arbitration between elements (R2 R3)
    for (int i = 0; i < 2; i++) exp_wr(32'h700 + 2*i, pat(32'h600) & 32'hFFFF, 2'd1);
    for (int i = 0; i < 2; i++) exp_wr(32'h900, pat(32'h800 + i) & 32'hFF, 2'd0);
    for (int i = 2; i < 6; i++) exp_wr(32'h700 + 2*i, pat(32'h600) & 32'hFFFF, 2'd1);
    setup(3, 32'h600, 32'h700, 6);
    setup(1, 32'h800, 32'h900, 2);
    wr(12, cw(1, 0, 2'd0, 0, 0, 1, 2'd1, 2'd1, 0, 0));
    wr(4,  cw(1, 0, 2'd1, 0, 1, 0, 2'd0, 2'd0, 0, 0));
    begin
      bit seen_req = 0;
      for (int c = 0; c < 20; c++) begin
        @(negedge clk);
        if (mem_req) seen_req = 1;
      end
      check("R3 no bus activity without request", {31'b0, seen_req}, 0);
    end
    begin
      int k3 = 0;
      int k1 = 0;
      int t  = 0;
      dreq[3] = 1'b1;
      while (k3 < 6 && t < 3000) begin
        @(negedge clk);
        t++;
        if (dack[3]) k3++;
        if (dack[1]) k1++;
        if (k3 == 2 && k1 == 0) dreq[1] = 1'b1;
        if (k1 == 2) dreq[1] = 1'b0;
        if (k3 == 6) dreq[3] = 1'b0;
      end
      dreq = '0;
      check("R3 ch1 acknowledge pulses", 32'(k1), 2);
      check("R3 ch3 acknowledge pulses", 32'(k3), 6);
    end
    drain("R2 s3 higher channel served between elements");
    rd_chk("R7 s3 flags", FLAGS, (32'h3 << 3) | (32'h3 << 9));
    wr(FLAGS, 32'h7FFF);

    // S4: half flag timing on an odd count (R8 R10)
    for (int i = 0; i < 5; i++) exp_wr(32'h700 + 4*i, pat(32'h600), 2'd2);
    setup(3, 32'h600, 32'h700, 5);
    wr(12, cw(1, 0, 2'd0, 0, 0, 1, 2'd2, 2'd2, 0, 1));
    pulse_req(3, 2);
    rd_chk("R8 s4 no half flag at 3 left", FLAGS, 0);
    rd_chk("R7 s4 count 3 left", 15, 3);
    pulse_req(3, 1);
    rd_chk("R8 s4 half flag at 2 left", FLAGS, 32'h1 << 10);
    check("R10 s4 irq from half", {27'b0, irq}, 32'h8);
    pulse_req(3, 2);
    drain("R7 s4 all writes seen");
    rd_chk("R7 s4 flags at end", FLAGS, 32'h3 << 9);
    wr(FLAGS, 32'h7FFF);
    check("R10 s4 irq cleared", {27'b0, irq}, 0);

    // S4b: software trigger on a peripheral channel (R3)
    for (int i = 0; i < 2; i++) exp_wr(32'h910 + 4*i, pat(32'h810 + 4*i), 2'd2);
    setup(1, 32'h810, 32'h910, 2);
    wr(4, cw(1, 1, 2'd0, 0, 1, 1, 2'd2, 2'd2, 0, 0));
    drain("R3 software trigger runs channel");
    wr(FLAGS, 32'h7FFF);

    // S5: circular reload (R9)
    for (int k = 0; k < 6; k++)
      exp_wr(32'h200 + 4*(k % 2), pat(32'h100 + 4*(k % 2)), 2'd2);
    setup(0, 32'h100, 32'h200, 2);
    wr(0, cw(1, 0, 2'd0, 1, 1, 1, 2'd2, 2'd2, 1, 0));
    pulse_req(0, 6);
    drain("R9 s5 wrapped writes");
    rd_chk("R9 s5 count reloaded", 3, 2);
    rd_chk("R9 s5 source reloaded", 1, 32'h100);
    rd_chk("R9 s5 dest reloaded", 2, 32'h200);
    check("R10 s5 irq completion", {27'b0, irq}, 32'h1);
    wr(0, 0);
    wr(FLAGS, 32'h7FFF);

    // S6: bus error (R11)
    setup(2, 32'hE000_0000, 32'h300, 3);
    wr(8, cw(1, 0, 2'd2, 0, 1, 1, 2'd2, 2'd2, 0, 0));
    repeat (30) @(negedge clk);
    rd_chk("R11 error flag", FLAGS, 32'h1 << 8);
    rd_chk("R11 enable cleared", 8, cw(0, 0, 2'd2, 0, 1, 1, 2'd2, 2'd2, 0, 0));
    rd_chk("R11 count not consumed", 11, 3);
    check("R11 irq from error", {27'b0, irq}, 32'h4);
    check("R11 no writes expected pending", qa.size(), 0);
    wr(FLAGS, 32'h1 << 8);
    check("R10 irq after error clear", {27'b0, irq}, 0);

    report();
  end

endmodule